// File: doc/BRIEF.md
# Pretrigger Capture Controller

This block steers probe samples into a fixed-depth sample buffer so that one capture window of exactly `DEPTH` samples is kept, with the trigger event at a programmable slot inside that window. In single-shot mode it writes every cycle into a circular buffer while it waits for the trigger. The samples that came before the trigger are therefore still present when the trigger fires. It stops once the part of the window after the trigger has been filled.

Two other modes do not use the trigger position. Incremental mode stores a sample only on the cycles where the trigger input is high. Immediate mode stores `DEPTH` consecutive samples as soon as the capture starts and pays no attention to the trigger.

The block reports completion through a sticky done flag. A read port returns the kept samples oldest first, whatever the wrap position of the circular buffer. The trigger condition is computed outside this block, and so is any host access.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, `done` is 0, the mode is single-shot and the pretrigger count is `DEPTH/2`. A capture started without any configuration write uses these values.
- R2: Single-shot mode uses mode code 0 (code 3 acts the same way). If `pos` is the pretrigger count and the trigger is accepted on cycle `t`, readback address `i` returns the probe value sampled on cycle `t-pos+i`, for `i` from 0 to `DEPTH-1`. The trigger sample therefore sits at address `pos`.
- R3: In single-shot mode the first `pos` samples after the start are the pretrigger fill. The trigger input is ignored during these cycles, so the first trigger that can be accepted is on cycle `pos+1`, counting the start edge as cycle 0.
- R4: `done` becomes visible after the clock edge that writes the last sample of the window. In single-shot mode that edge is `t+DEPTH-pos-1`. In immediate mode it is edge `DEPTH`. In incremental mode it is the edge that stores the `DEPTH`-th qualifying sample.
- R5: Incremental mode uses mode code 1. Only the probe values of cycles where `trigIn` is high are stored, in order. Address 0 holds the first of them.
- R6: Immediate mode uses mode code 2. It stores the probe values of cycles 1 to `DEPTH` after the start edge, whatever `trigIn` does.
- R7: A programmed pretrigger count of `DEPTH` or more is clamped to `DEPTH-1`.
- R8: `done` stays high until a start command arrives. That start clears `done` on the next edge and returns the block to idle. Idle writes nothing, and a second start is needed to begin a new capture.
- R9: While a capture is in progress, both configuration writes and start commands are ignored.
- R10: `rdData` presents the sample selected by `rdAddr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Load `cfgMode` and `cfgTrigPos` when not capturing |
| cfgMode | input | 2 | Capture mode: 0 single-shot, 1 incremental, 2 immediate, 3 single-shot |
| cfgTrigPos | input | $clog2(DEPTH)+1 | Requested number of pretrigger samples (clamped) |
| startCmd | input | 1 | Start a capture from idle, or clear a finished one |
| trigIn | input | 1 | Externally evaluated trigger condition |
| probeIn | input | DATA_W | Probe sample bus |
| done | output | 1 | Capture window complete |
| rdAddr | input | $clog2(DEPTH) | Readback index, 0 = oldest sample |
| rdData | output | DATA_W | Sample at `rdAddr`, one cycle later |

## Verification
The start edge counts as cycle 0. Fresh probe and trigger values are driven at every falling edge, and each value is logged against the rising edge that consumes it. The expected done edge follows from R4 through the accepted trigger cycle, or the count of qualifying cycles, and `done` is sampled at the falling edge right after that rising edge. This detects a done that is one cycle early or late. Readback puts an address on the bus at a falling edge and compares `rdData` one full clock later. The checks after completion sample `done` for several cycles, both before and after the clearing start, and read address 0 again to confirm that idle wrote nothing.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_INCR   = 2'd1;
  localparam logic [1:0] MODE_IMMED  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARMED,
    ST_CAPTURE,
    ST_DONE
  } capState_t;

  typedef struct packed {
    logic wrEn;
    logic clrPtr;
    logic markTrig;
  } strobe_t;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWr,
  input  logic [1:0]    cfgMode,
  input  logic [AW:0]   cfgTrigPos,
  input  logic          startCmd,
  input  logic          trigIn,
  output strobe_t       strb,
  output logic [AW-1:0] trigPos,
  output logic          done
);
  localparam int CW = AW + 1;

  capState_t     state;
  logic [1:0]    modeR;
  logic [AW-1:0] posR;
  logic [CW-1:0] cnt;
  logic [AW-1:0] clampPos;
  logic [CW-1:0] postLen;
  logic          cfgOpen;
  logic          trigFree;

  assign clampPos = (cfgTrigPos >= CW'(DEPTH)) ? AW'(DEPTH - 1) : cfgTrigPos[AW-1:0];
  assign postLen  = CW'(DEPTH - 1) - {1'b0, posR};
  assign cfgOpen  = (state == ST_IDLE) || (state == ST_DONE);
  assign trigFree = (modeR == MODE_INCR) || (modeR == MODE_IMMED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeR <= MODE_SINGLE;
      posR  <= AW'(DEPTH / 2);
      cnt   <= '0;
    end else begin
      if (cfgWr && cfgOpen) begin
        modeR <= cfgMode;
        posR  <= clampPos;
      end
      case (state)
        ST_IDLE: if (startCmd) begin
          if (trigFree) begin
            state <= ST_CAPTURE;
            cnt   <= CW'(DEPTH);
          end else if (posR == '0) begin
            state <= ST_ARMED;
          end else begin
            state <= ST_FILL;
            cnt   <= {1'b0, posR};
          end
        end
        ST_FILL: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_ARMED;
        end
        ST_ARMED: if (trigIn) begin
          if (postLen == '0) begin
            state <= ST_DONE;
          end else begin
            state <= ST_CAPTURE;
            cnt   <= postLen;
          end
        end
        ST_CAPTURE: if (strb.wrEn) begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_DONE;
        end
        ST_DONE: if (startCmd) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.wrEn     = (state == ST_FILL) || (state == ST_ARMED) ||
                    ((state == ST_CAPTURE) && ((modeR != MODE_INCR) || trigIn));
    strb.clrPtr   = (state == ST_IDLE) && startCmd;
    strb.markTrig = (state == ST_ARMED) && trigIn;
  end

  assign trigPos = posR;
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [AW-1:0]     trigPos,
  input  logic [DATA_W-1:0] probeIn,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     startPtr;
  logic [AW-1:0]     rdIdx;

  assign rdIdx = startPtr + rdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      startPtr <= '0;
    end else if (strb.clrPtr) begin
      wrPtr    <= '0;
      startPtr <= '0;
    end else begin
      if (strb.markTrig) startPtr <= wrPtr - trigPos;
      if (strb.wrEn)     wrPtr    <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= probeIn;
    rdData <= mem[rdIdx];
  end

endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWr,
  input  logic [1:0]               cfgMode,
  input  logic [$clog2(DEPTH):0]   cfgTrigPos,
  input  logic                     startCmd,
  input  logic                     trigIn,
  input  logic [DATA_W-1:0]        probeIn,
  output logic                     done,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [DATA_W-1:0]        rdData
);
  localparam int AW = $clog2(DEPTH);

  strobe_t       strb;
  logic [AW-1:0] trigPos;

  cap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode),
    .cfgTrigPos(cfgTrigPos), .startCmd(startCmd), .trigIn(trigIn),
    .strb(strb), .trigPos(trigPos), .done(done)
  );

  cap_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trigPos(trigPos),
    .probeIn(probeIn), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/cap_checker.sv
module cap_checker (
  input logic clk,
  input logic rstN,
  input logic startCmd,
  input logic done,
  input logic wrEn,
  input logic markTrig,
  input logic clrPtr
);
  AST_DONE_STICKY:   assert property (@(posedge clk) disable iff (!rstN) done && !startCmd |=> done);   // R8
  AST_START_CLEARS:  assert property (@(posedge clk) disable iff (!rstN) done && startCmd |=> !done);   // R8
  AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rstN) done |-> !wrEn);              // R4
  AST_MARK_WRITES:   assert property (@(posedge clk) disable iff (!rstN) markTrig |-> wrEn);           // R2
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) clrPtr |-> !wrEn);            // R8
  AST_CLEAR_NO_DONE: assert property (@(posedge clk) disable iff (!rstN) clrPtr |=> !done);            // R9
endmodule

bind pretrig_capture cap_checker u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .done(done),
  .wrEn(strb.wrEn), .markTrig(strb.markTrig), .clrPtr(strb.clrPtr)
);

// File: tb/pretrig_capture_test.sv
module pretrig_capture_test;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int LOGN   = 600;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWr = 1'b0;
  logic [1:0]        cfgMode = '0;
  logic [AW:0]       cfgTrigPos = '0;
  logic              startCmd = 1'b0;
  logic              trigIn = 1'b0;
  logic [DATA_W-1:0] probeIn = '0;
  logic              done;
  logic [AW-1:0]     rdAddr = '0;
  logic [DATA_W-1:0] rdData;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;
  int mMode = 0;
  int mPos = DEPTH / 2;
  int probeLog [LOGN];
  bit trigLog [LOGN];
  int expV [DEPTH];

  always #5 clk = ~clk;

  pretrig_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode),
    .cfgTrigPos(cfgTrigPos), .startCmd(startCmd), .trigIn(trigIn),
    .probeIn(probeIn), .done(done), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int clampModel(input int p);
    return (p >= DEPTH) ? DEPTH - 1 : p;
  endfunction

  task automatic configure(input int mode, input int pos);
    @(negedge clk);
    cfgWr = 1'b1;
    cfgMode = 2'(mode);
    cfgTrigPos = (AW + 1)'(pos);
    @(negedge clk);
    cfgWr = 1'b0;
    mMode = (mode == 3) ? 0 : mode;
    mPos = clampModel(pos);
  endtask

  task automatic readBack(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      rdAddr = AW'(i);
      @(negedge clk);
      chk(int'(rdData) == expV[i], req, int'(rdData), expV[i]);
    end
  endtask

  // Runs one capture from idle; forceFill drives the trigger high for the
  // whole pretrigger fill; poke tries a config write and a start mid-capture.
  task automatic runCapture(input bit forceFill, input bit poke);
    int cyc, doneC, t, expDone, k;
    string req;
    @(negedge clk);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    doneC = -1;
    cyc = 0;
    while (doneC < 0 && cyc < 400) begin
      cyc++;
      probeIn = DATA_W'($urandom);
      if (mMode == 0)
        trigIn = (forceFill && cyc <= mPos) ? 1'b1 :
                 (cyc >= mPos + 30) ? 1'b1 : ($urandom % 6 == 0);
      else if (mMode == 1)
        trigIn = ($urandom % 3 == 0);
      else
        trigIn = 1'($urandom % 2);
      if (poke && cyc == 2) begin
        cfgWr = 1'b1;
        cfgMode = (mMode == 2) ? 2'd0 : 2'd2;
        cfgTrigPos = '0;
        startCmd = 1'b1;
      end else begin
        cfgWr = 1'b0;
        startCmd = 1'b0;
      end
      probeLog[cyc] = int'(probeIn);
      trigLog[cyc] = trigIn;
      @(negedge clk);
      if (done) doneC = cyc;
    end
    trigIn = 1'b0;
    cfgWr = 1'b0;
    startCmd = 1'b0;
    expDone = -1;
    if (mMode == 0) begin
      req = poke ? "R9" : "R2";
      t = -1;
      for (int c = mPos + 1; c <= cyc; c++)
        if (t < 0 && trigLog[c]) t = c;
      if (t > 0) begin
        expDone = t + DEPTH - mPos - 1;
        if (expDone <= cyc)
          for (int i = 0; i < DEPTH; i++) expV[i] = probeLog[t - mPos + i];
      end
    end else if (mMode == 1) begin
      req = poke ? "R9" : "R5";
      k = 0;
      for (int c = 1; c <= cyc; c++)
        if (trigLog[c] && k < DEPTH) begin
          expV[k] = probeLog[c];
          k++;
          if (k == DEPTH) expDone = c;
        end
    end else begin
      req = poke ? "R9" : "R6";
      expDone = DEPTH;
      if (expDone <= cyc)
        for (int i = 0; i < DEPTH; i++) expV[i] = probeLog[1 + i];
    end
    chk(doneC == expDone && expDone > 0, "R4 done cycle", doneC, expDone);
    if (expDone > 0 && expDone <= cyc) readBack(req);
  endtask

  // R8 / R10: done holds, start clears it, idle writes nothing.
  task automatic clearDone();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done == 1'b1, "R8 done held", int'(done), 1);
    end
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    chk(done == 1'b0, "R8 start clears done", int'(done), 0);
    probeIn = DATA_W'($urandom);
    rdAddr = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8 stays idle", int'(done), 0);
    end
    chk(int'(rdData) == expV[0], "R10 idle keeps buffer", int'(rdData), expV[0]);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    // R1 default config, R3 trigger held high through the fill
    runCapture(1'b1, 1'b0);
    clearDone();
    configure(0, 0);                  // R2 no pretrigger samples
    runCapture(1'b0, 1'b0);
    clearDone();
    configure(3, DEPTH + 3);          // R7 clamp, code 3 single-shot
    runCapture(1'b1, 1'b0);
    clearDone();
    configure(0, 2 * DEPTH - 1);      // R7 largest request
    runCapture(1'b0, 1'b0);
    clearDone();
    configure(0, 5);                  // R3 fill then armed
    runCapture(1'b1, 1'b0);
    clearDone();
    configure(1, 7);                  // R5 incremental
    runCapture(1'b0, 1'b0);
    clearDone();
    configure(2, 3);                  // R6 immediate
    runCapture(1'b0, 1'b0);
    clearDone();
    configure(0, 6);                  // R9 ignored writes mid-capture
    runCapture(1'b0, 1'b1);
    clearDone();
    runCapture(1'b0, 1'b0);           // R9 old config still in force
    clearDone();
    for (int r = 0; r < 10; r++) begin
      configure(int'($urandom % 4), int'($urandom % (2 * DEPTH)));
      runCapture(1'($urandom % 2), 1'($urandom % 2));
      clearDone();
    end
    finished = 1;
    summary();
  end

endmodule